// File: doc/BRIEF.md
# Merging Store Buffer for a Write-Through Cache

This block sits between a write-through first-level data cache and the next cache level down. It takes each processor store into one of a small number of line-sized entries and writes those entries to the lower level in the background. The processor therefore does not wait for each store to complete. A store to a line that already has a waiting entry is folded into that entry. This saves lower-level write traffic and entries.

To decide whether a store can be folded, the block first compares only the address bits that choose the lower-level set. It compares the rest of the line address only when those bits agree. Stores to the uncached device region are never folded, so each one reaches the lower level separately and in program order. A read probe port reports whether a read line has a write still waiting in the buffer. The processor then holds that read until the buffer drains, or sends it ahead of the waiting writes when there is no conflict.

Top module: `merging_wbuf`

## Requirements
- R1: After reset the buffer is empty: `wr_valid` is 0, `st_stall` is 0 and `rd_conflict` is 0.
- R2: A store presented with `st_valid` high while `st_stall` is low is accepted on that clock edge. If it cannot be folded, it takes a new entry at the young end of the queue.
- R3: A store whose line address (the address bits above the byte offset) equals that of a waiting, non-device entry other than the oldest is folded into that entry. Its byte enables are ORed into the entry's byte mask, the enabled bytes are overwritten, and no entry is added.
- R4: Folding requires first that the low `SET_W` bits of the line address agree, and then that the remaining line-address bits agree. A store in the same lower-level set with a different line takes its own entry.
- R5: A store whose address satisfies `(addr & IO_MASK) == IO_BASE` never folds, and no later store folds into it. Each such store occupies its own entry and drains in arrival order.
- R6: The oldest entry is the one on offer to the lower level and takes no further folds. While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_be` hold steady.
- R7: Entries drain oldest first, one per cycle in which `wr_valid` and `wr_ready` are both high. `wr_valid` is high whenever any entry is waiting. `wr_addr` is the line address with zero byte-offset bits, and `wr_be` is the entry's byte mask.
- R8: `st_stall` is high exactly when all `DEPTH` entries are waiting and the store on the store port cannot be folded. A drain in the same cycle does not lower it.
- R9: `rd_conflict` is high, in the same cycle, when any waiting entry (including the oldest and device entries) holds the line given on `rd_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | LINE_BYTES*8 | Store data, line aligned |
| st_be | input | LINE_BYTES | Store byte enables |
| st_stall | output | 1 | Store cannot be accepted this cycle |
| rd_line | input | ADDR_W-log2(LINE_BYTES) | Line address of a pending read |
| rd_conflict | output | 1 | Read line has a waiting write |
| wr_valid | output | 1 | Lower-level write on offer |
| wr_ready | input | 1 | Lower level takes the write |
| wr_addr | output | ADDR_W | Line-aligned write address |
| wr_data | output | LINE_BYTES*8 | Write data |
| wr_be | output | LINE_BYTES | Write byte mask |

## Verification
The bench builds the block with four entries, 8-byte lines, six set bits and the device region at the top 256 MB of the address space. With these values the lines at 0x100 and 0x300 share a set while differing in line address, so a single store reaches the pre-compare-only path. Four stores fill the buffer, which brings the full-with-fold and full-without-fold stall cases within reach in a short sequence. Holding `wr_ready` low keeps the oldest entry locked on offer, which exposes both folding into a younger duplicate of that line and the stability of the offered write.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_FOLD  = 2'd1,
      ACT_ALLOC = 2'd2,
      ACT_HOLD  = 2'd3
   } st_act_e;
endpackage

// File: rtl/mwb_match.sv
module mwb_match #(
   parameter int BLK_W      = 29,
   parameter int SET_W      = 6,
   parameter int DEPTH      = 4,
   parameter bit PRECOMPARE = 1'b1
) (
   input  logic [BLK_W-1:0] ent_blk [DEPTH],
   input  logic [DEPTH-1:0] ent_valid,
   input  logic [DEPTH-1:0] ent_open,
   input  logic [BLK_W-1:0] key_blk,
   input  logic [BLK_W-1:0] probe_blk,
   output logic [DEPTH-1:0] fold_hit,
   output logic [DEPTH-1:0] probe_hit
);
   localparam int TAG_W = BLK_W - SET_W;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      if (PRECOMPARE) begin : g_two_stage
         logic set_eq;
         assign set_eq      = ent_open[i] &&
                              (ent_blk[i][SET_W-1:0] == key_blk[SET_W-1:0]);
         assign fold_hit[i] = set_eq &&
                              (ent_blk[i][BLK_W-1:SET_W] == key_blk[BLK_W-1:SET_W]);
      end else begin : g_flat
         assign fold_hit[i] = ent_open[i] && (ent_blk[i] == key_blk);
      end
      assign probe_hit[i] = ent_valid[i] && (ent_blk[i] == probe_blk);
   end

   if (TAG_W < 1) begin : g_bad_set
      $error("SET_W must leave at least one tag bit");
   end
endmodule

// File: rtl/mwb_queue_ctl.sv
module mwb_queue_ctl #(
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic           pop,
   output logic [PTR_W-1:0] head,
   output logic [PTR_W-1:0] tail,
   output logic [PTR_W:0]   count,
   output logic             full
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign full = (count == (PTR_W+1)'(DEPTH));
endmodule

// File: rtl/merging_wbuf.sv
module merging_wbuf
   import mwb_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          LINE_BYTES = 8,
   parameter int          DEPTH      = 4,
   parameter int          SET_W      = 6,
   parameter bit          PRECOMPARE = 1'b1,
   parameter logic [31:0] IO_BASE    = 32'hF000_0000,
   parameter logic [31:0] IO_MASK    = 32'hF000_0000,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int BLK_W  = ADDR_W - OFF_W,
   localparam int DATA_W = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic [LINE_BYTES-1:0] st_be,
   output logic              st_stall,
   input  logic [BLK_W-1:0]  rd_line,
   output logic              rd_conflict,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [LINE_BYTES-1:0] wr_be
);
   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W is limited to 32 by the region parameters");
   end

   logic [BLK_W-1:0]      e_blk  [DEPTH];
   logic [DATA_W-1:0]     e_data [DEPTH];
   logic [LINE_BYTES-1:0] e_mask [DEPTH];
   logic [DEPTH-1:0]      e_valid, e_io, e_open;
   logic [DEPTH-1:0]      fold_hit, probe_hit;

   logic [PTR_W-1:0] head, tail, fold_idx;
   logic [PTR_W:0]   count;
   logic             full, push, pop, st_io, fold_ok, fold_fire;
   logic [BLK_W-1:0] st_blk;
   st_act_e          act;

   assign st_blk = st_addr[ADDR_W-1:OFF_W];
   assign st_io  = ((st_addr & IO_MASK[ADDR_W-1:0]) == IO_BASE[ADDR_W-1:0]);

   for (genvar i = 0; i < DEPTH; i++) begin : g_open
      assign e_open[i] = e_valid[i] && !e_io[i] && (PTR_W'(i) != head);
   end

   mwb_match #(
      .BLK_W(BLK_W), .SET_W(SET_W), .DEPTH(DEPTH), .PRECOMPARE(PRECOMPARE)
   ) u_match (
      .ent_blk   (e_blk),
      .ent_valid (e_valid),
      .ent_open  (e_open),
      .key_blk   (st_blk),
      .probe_blk (rd_line),
      .fold_hit  (fold_hit),
      .probe_hit (probe_hit)
   );

   always_comb begin
      fold_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (fold_hit[i]) fold_idx = PTR_W'(i);
      end
   end

   assign fold_ok = (|fold_hit) && !st_io;

   always_comb begin
      if (!st_valid)    act = ACT_NONE;
      else if (fold_ok) act = ACT_FOLD;
      else if (full)    act = ACT_HOLD;
      else              act = ACT_ALLOC;
   end

   assign st_stall  = full && !fold_ok;
   assign push      = (act == ACT_ALLOC);
   assign fold_fire = (act == ACT_FOLD);
   assign pop       = wr_valid && wr_ready;

   mwb_queue_ctl #(.DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .head  (head),
      .tail  (tail),
      .count (count),
      .full  (full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_valid <= '0;
         e_io    <= '0;
      end else begin
         if (pop) e_valid[head] <= 1'b0;
         if (push) begin
            e_valid[tail] <= 1'b1;
            e_io[tail]    <= st_io;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         e_blk[tail]  <= st_blk;
         e_data[tail] <= st_data;
         e_mask[tail] <= st_be;
      end else if (fold_fire) begin
         e_mask[fold_idx] <= e_mask[fold_idx] | st_be;
         for (int b = 0; b < LINE_BYTES; b++) begin
            if (st_be[b]) e_data[fold_idx][b*8 +: 8] <= st_data[b*8 +: 8];
         end
      end
   end

   assign wr_valid    = e_valid[head];
   assign wr_addr     = {e_blk[head], {OFF_W{1'b0}}};
   assign wr_data     = e_data[head];
   assign wr_be       = e_mask[head];
   assign rd_conflict = |probe_hit;
endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 8,
   parameter int DEPTH      = 4,
   localparam int DATA_W = LINE_BYTES * 8,
   localparam int CNT_W  = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_stall,
   input logic              st_io,
   input logic              fold_fire,
   input logic              push,
   input logic              full,
   input logic [CNT_W-1:0]  count,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [LINE_BYTES-1:0] wr_be
);
   // R8: a stall is only raised with every entry occupied
   a_r8_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      st_stall |-> (count == CNT_W'(DEPTH)) && full);

   // R6: the offered write holds until taken
   a_r6_offer_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) &&
                                  $stable(wr_data) && $stable(wr_be));

   // R5: device-region stores never fold
   a_r5_io_never_folds: assert property (@(posedge clk) disable iff (!rst_n)
      fold_fire |-> !st_io);

   // R7: something is offered exactly when the queue holds entries
   a_r7_offer_when_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0) == wr_valid);

   // R2: an allocation without a drain grows the queue by one
   a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !(wr_valid && wr_ready)) |=> count == $past(count) + 1'b1);

   // R3: a fold without a drain leaves occupancy unchanged
   a_r3_fold_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (fold_fire && !(wr_valid && wr_ready)) |=> count == $past(count));

   // R2: occupancy never exceeds the entry count
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
endmodule

bind merging_wbuf mwb_checker #(
   .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DEPTH(DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_stall  (st_stall),
   .st_io     (st_io),
   .fold_fire (fold_fire),
   .push      (push),
   .full      (full),
   .count     (count),
   .wr_valid  (wr_valid),
   .wr_ready  (wr_ready),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .wr_be     (wr_be)
);

// File: tb/merging_wbuf_tb.sv
module merging_wbuf_tb;
   localparam int ADDR_W = 32;
   localparam int LB     = 8;
   localparam int DW     = LB * 8;
   localparam int BW     = ADDR_W - 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0;
   logic [31:0]   st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic [LB-1:0] st_be = '0;
   logic          st_stall;
   logic [BW-1:0] rd_line = '0;
   logic          rd_conflict;
   logic          wr_valid;
   logic          wr_ready = 1'b0;
   logic [31:0]   wr_addr;
   logic [DW-1:0] wr_data;
   logic [LB-1:0] wr_be;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   merging_wbuf #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LB), .DEPTH(4), .SET_W(6), .PRECOMPARE(1'b1),
      .IO_BASE(32'hF000_0000), .IO_MASK(32'hF000_0000)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
      .st_stall(st_stall), .rd_line(rd_line), .rd_conflict(rd_conflict),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be)
   );

   localparam int NV = 9;
   localparam logic [31:0] V_ADDR [NV] = '{32'h100, 32'h100, 32'h104, 32'h300,
      32'hF000_0010, 32'hF000_0010, 32'h300, 32'h100, 32'h500};
   localparam logic [7:0] V_BE   [NV] = '{8'h0F, 8'hF0, 8'h01, 8'hFF, 8'h03,
      8'h03, 8'h02, 8'h02, 8'hFF};
   localparam logic [7:0] V_BYTE [NV] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55,
      8'h66, 8'h77, 8'h88, 8'h99};
   localparam bit V_STALL [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 1};

   function automatic logic [DW-1:0] masked(logic [DW-1:0] d, logic [LB-1:0] m);
      logic [DW-1:0] r = '0;
      for (int b = 0; b < LB; b++) if (m[b]) r[b*8 +: 8] = d[b*8 +: 8];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic store(input logic [31:0] a, input logic [7:0] be,
                        input logic [7:0] byt, input bit exp_stall, input string req);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_be = be; st_data = {LB{byt}};
      #1;
      check(st_stall == exp_stall, req, 64'(st_stall), 64'(exp_stall));
      @(posedge clk);
      #1;
      st_valid = 1'b0;
   endtask

   task automatic expect_drain(input logic [31:0] a, input logic [7:0] be,
                               input logic [63:0] d, input string req);
      @(negedge clk);
      wr_ready = 1'b1;
      #1;
      check(wr_valid == 1'b1, req, 64'(wr_valid), 64'd1);
      check(wr_addr == a, req, 64'(wr_addr), 64'(a));
      check(wr_be == be, req, 64'(wr_be), 64'(be));
      check(masked(wr_data, wr_be) == d, req, masked(wr_data, wr_be), d);
      @(posedge clk);
      #1;
      wr_ready = 1'b0;
   endtask

   task automatic probe(input logic [31:0] a, input bit exp, input string req);
      @(negedge clk);
      rd_line = a[31:3];
      #1;
      check(rd_conflict == exp, req, 64'(rd_conflict), 64'(exp));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: empty after reset
      check(wr_valid == 1'b0, "R1", 64'(wr_valid), 64'd0);
      check(st_stall == 1'b0, "R1", 64'(st_stall), 64'd0);
      check(rd_conflict == 1'b0, "R1", 64'(rd_conflict), 64'd0);

      // Vector walk with the lower level blocked: R2 R3 R4 R5 R8
      for (int v = 0; v < NV; v++) begin
         store(V_ADDR[v], V_BE[v], V_BYTE[v], V_STALL[v], V_STALL[v] ? "R8" : "R2");
      end

      // R6: oldest entry stayed locked despite later stores to its line
      #1;
      check(wr_addr == 32'h100, "R6", 64'(wr_addr), 64'h100);
      check(wr_be == 8'h0F, "R6", 64'(wr_be), 64'h0F);

      // R9: read probes
      probe(32'h107, 1'b1, "R9");
      probe(32'h300, 1'b1, "R9");
      probe(32'hF000_0010, 1'b1, "R9");
      probe(32'h500, 1'b0, "R9");
      probe(32'h900, 1'b0, "R9 R4 same set other line");

      // R7 drain order; R3 fold contents; R4 separate same-set line; R5 device store
      expect_drain(32'h100, 8'h0F, 64'h0000_0000_1111_1111, "R7");
      expect_drain(32'h100, 8'hF3, 64'h2222_2222_0000_8833, "R3");
      expect_drain(32'h300, 8'hFF, 64'h4444_4444_4444_7744, "R4");
      expect_drain(32'hF000_0010, 8'h03, 64'h0000_0000_0000_5555, "R5");
      @(negedge clk);
      #1;
      check(wr_valid == 1'b0, "R7", 64'(wr_valid), 64'd0);
      check(st_stall == 1'b0, "R8", 64'(st_stall), 64'd0);
      probe(32'h100, 1'b0, "R9");

      // Repeated device stores keep separate entries in order: R5
      store(32'hF000_0020, 8'h01, 8'hAA, 1'b0, "R5");
      store(32'hF000_0020, 8'h02, 8'hBB, 1'b0, "R5");
      store(32'h0000_0040, 8'h01, 8'hCC, 1'b0, "R2");
      store(32'h0000_0040, 8'h04, 8'hDD, 1'b0, "R3");
      expect_drain(32'hF000_0020, 8'h01, 64'h0000_0000_0000_00AA, "R5");
      expect_drain(32'hF000_0020, 8'h02, 64'h0000_0000_0000_BB00, "R5");
      expect_drain(32'h0000_0040, 8'h05, 64'h0000_0000_00DD_00CC, "R3");
      @(negedge clk);
      #1;
      check(wr_valid == 1'b0, "R7", 64'(wr_valid), 64'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule